// File: doc/BRIEF.md
# Sub-word Load/Store Lane Unit

This block sits between the load/store path of a processor and a data memory that is one 8-byte word wide. Each request carries a byte address, an access size of 1, 2, 4 or 8 bytes, a load/store flag and, for stores, 64 bits of store data. The block splits the address into a word index and a byte offset and drives the memory controls. For a load it pulls the addressed lane out of the returned word and zero-extends it. For a store narrower than the word it reads the current word and writes back a merged word.

Lanes are numbered big-endian: byte offset 0 is the most significant byte of the word. The memory is read synchronously, so read data arrives one cycle after the read is issued. The block has no byte enables, so a partial store takes two cycles: a read, then a write of the merged word. A request whose offset is not a multiple of its size is refused and flagged as unaligned.

Top module: `subword_lane_unit`

## Requirements
- R1: For an aligned request, `mem_idx` equals the byte address shifted right by 3, and the byte offset is the low 3 address bits.
- R2: A request is aligned only when its offset is a multiple of its size. An unaligned request drives no memory access and produces no load result. `misalign_err` pulses high for the one cycle after such a request.
- R3: Lanes are big-endian. Within the word, byte offset k occupies bits [63-8k -: 8], so a lane of n bytes at offset k sits (8-n-k)×8 bits above bit 0.
- R4: A load narrower than 8 bytes returns the lane in the low n×8 bits of `ld_data`, and all higher bits are zero.
- R5: An 8-byte load returns the memory word unchanged.
- R6: An 8-byte store writes `req_wdata` in the cycle it is accepted (`mem_en`=1, `mem_we`=1), with no read and without raising `busy`.
- R7: A store narrower than 8 bytes reads the word in the accept cycle (`mem_we`=0). In the next cycle `busy` is high and the block writes the old word with only the target lane replaced.
- R8: Only the low n×8 bits of `req_wdata` are stored. The higher bits have no effect on memory.
- R9: While `busy` is high, `req_valid` is ignored and the request causes no memory effect.
- R10: A word that has never been written reads as zero, both for loads and for the read half of a partial store.
- R11: `ld_valid` is a one-cycle pulse two cycles after the load is accepted, which is one cycle after the memory read data returns. `ld_data` holds the result in that cycle.
- R12: Size code on `req_size`: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 = 8 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code (R12) |
| req_wdata | input | 64 | Store data, right-justified |
| busy | output | 1 | Write half of a partial store in progress |
| misalign_err | output | 1 | Unaligned request flag, one-cycle pulse |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_idx | output | ADDR_W-3 | Word index |
| mem_wdata | output | 64 | Word to write |
| mem_rdata | input | 64 | Word read, valid one cycle after a read |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Zero-extended load result |

## Verification
The hardest case to reach from the ports is a new request that arrives in the write cycle of a partial store. The write cycle must use the held index and lane, and it must not be disturbed by the new request. The bench reaches this by holding `req_valid` high with a conflicting full-width store through the busy cycle. It then reads back both the target word and the intruder's word. Partial stores into never-written words, and store data whose upper bits are all ones, expose merge and masking faults that a pre-filled memory would hide.

// File: rtl/lane_pkg.sv
package lane_pkg;
  localparam int WORD_BYTES = 8;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int SZ_W       = 2;

  typedef enum logic [SZ_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_QUAD = 2'd2,
    SZ_FULL = 2'd3
  } size_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_WRITE = 1'b1
  } lane_state_e;

  // number of bytes selected by a size code
  function automatic int unsigned size_bytes(input logic [SZ_W-1:0] sz);
    return 32'd1 << sz;
  endfunction

  // right-justified mask covering one lane
  function automatic logic [WORD_W-1:0] lane_mask(input logic [SZ_W-1:0] sz);
    int unsigned nb;
    nb = size_bytes(sz);
    if (nb >= WORD_BYTES) return '1;
    return (WORD_W'(1) << (nb * 8)) - WORD_W'(1);
  endfunction

  // bit distance of the lane from bit 0; offset 0 is the top of the word
  function automatic int unsigned lane_shift(input logic [SZ_W-1:0] sz,
                                             input logic [OFF_W-1:0] off);
    return (WORD_BYTES - size_bytes(sz) - int'(off)) * 8;
  endfunction

  function automatic logic lane_aligned(input logic [SZ_W-1:0] sz,
                                        input logic [OFF_W-1:0] off);
    int unsigned nb;
    nb = size_bytes(sz);
    if (nb > WORD_BYTES) return 1'b0;
    return (int'(off) & (nb - 1)) == 0;
  endfunction
endpackage

// File: rtl/lane_addr_split.sv
module lane_addr_split
  import lane_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int IDX_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SZ_W-1:0]   size,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  off,
  output logic              aligned,
  output logic              full
);
  always_comb begin
    idx     = addr[ADDR_W-1:OFF_W];
    off     = addr[OFF_W-1:0];
    aligned = lane_aligned(size, addr[OFF_W-1:0]);
    full    = (size_bytes(size) == WORD_BYTES);
  end
endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lane_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [SZ_W-1:0]   size,
  input  logic [OFF_W-1:0]  off,
  output logic [WORD_W-1:0] lane
);
  always_comb begin
    lane = (word >> lane_shift(size, off)) & lane_mask(size);
  end
endmodule

// File: rtl/lane_store_merge.sv
module lane_store_merge
  import lane_pkg::*;
(
  input  logic [WORD_W-1:0] old_word,
  input  logic [WORD_W-1:0] wdata,
  input  logic [SZ_W-1:0]   size,
  input  logic [OFF_W-1:0]  off,
  output logic [WORD_W-1:0] merged,
  output logic [WORD_W-1:0] lane_field
);
  logic [WORD_W-1:0] keep;
  always_comb begin
    lane_field = lane_mask(size) << lane_shift(size, off);
    keep       = old_word & ~lane_field;
    merged     = keep | ((wdata & lane_mask(size)) << lane_shift(size, off));
  end
endmodule

// File: rtl/subword_lane_unit.sv
module subword_lane_unit
  import lane_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int IDX_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              busy,
  output logic              misalign_err,
  output logic              mem_en,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [WORD_W-1:0] ld_data
);
  lane_state_e       state_q;
  logic [IDX_W-1:0]  cur_idx;
  logic [OFF_W-1:0]  cur_off;
  logic              cur_aligned, cur_full;

  // named events
  logic accept_w, issue_ld_w, issue_full_w, issue_rmw_w, reject_w, in_write_w;

  logic [IDX_W-1:0]  hold_idx_q;
  logic [OFF_W-1:0]  hold_off_q;
  logic [SZ_W-1:0]   hold_size_q;
  logic [WORD_W-1:0] hold_wdata_q;
  logic              pend_ld_q;
  logic [OFF_W-1:0]  pend_off_q;
  logic [SZ_W-1:0]   pend_size_q;
  logic [WORD_W-1:0] merged_w, lane_field_w, extract_w;

  lane_addr_split #(.ADDR_W(ADDR_W)) u_split (
    .addr(req_addr), .size(req_size), .idx(cur_idx), .off(cur_off),
    .aligned(cur_aligned), .full(cur_full)
  );

  assign in_write_w   = (state_q == ST_WRITE);
  assign busy         = in_write_w;
  assign accept_w     = req_valid && !in_write_w;
  assign issue_ld_w   = accept_w && !req_store && cur_aligned;
  assign issue_full_w = accept_w && req_store && cur_aligned && cur_full;
  assign issue_rmw_w  = accept_w && req_store && cur_aligned && !cur_full;
  assign reject_w     = accept_w && !cur_aligned;

  lane_store_merge u_merge (
    .old_word(mem_rdata), .wdata(hold_wdata_q), .size(hold_size_q),
    .off(hold_off_q), .merged(merged_w), .lane_field(lane_field_w)
  );

  lane_load_extract u_extract (
    .word(mem_rdata), .size(pend_size_q), .off(pend_off_q), .lane(extract_w)
  );

  always_comb begin
    mem_en    = in_write_w || issue_ld_w || issue_full_w || issue_rmw_w;
    mem_we    = in_write_w || issue_full_w;
    mem_idx   = in_write_w ? hold_idx_q : cur_idx;
    mem_wdata = in_write_w ? merged_w : req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      hold_idx_q   <= '0;
      hold_off_q   <= '0;
      hold_size_q  <= SZ_BYTE;
      hold_wdata_q <= '0;
      pend_ld_q    <= 1'b0;
      pend_off_q   <= '0;
      pend_size_q  <= SZ_BYTE;
      ld_valid     <= 1'b0;
      ld_data      <= '0;
      misalign_err <= 1'b0;
    end else begin
      misalign_err <= reject_w;
      pend_ld_q    <= issue_ld_w;
      if (issue_ld_w) begin
        pend_off_q  <= cur_off;
        pend_size_q <= req_size;
      end
      ld_valid <= pend_ld_q;
      if (pend_ld_q) ld_data <= extract_w;
      if (issue_rmw_w) begin
        state_q      <= ST_WRITE;
        hold_idx_q   <= cur_idx;
        hold_off_q   <= cur_off;
        hold_size_q  <= req_size;
        hold_wdata_q <= req_wdata;
      end else begin
        state_q <= ST_IDLE;
      end
    end
  end

  a_r2_no_access_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !cur_aligned) |-> !mem_en);
  a_r2_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> $past(req_valid && !busy && !cur_aligned));
  a_r6_direct_store_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !busy) |=> !busy);
  a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mem_en && !mem_we));
  a_r7_other_lanes_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (((mem_wdata ^ mem_rdata) & ~lane_field_w) == '0));
  a_r9_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  a_r11_result_timing: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_en && !mem_we && !busy, 2));
endmodule

// File: tb/subword_lane_unit_bench.sv
`timescale 1ns/1ps
module subword_lane_unit_bench;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = ADDR_W - 3;
  localparam int DEPTH  = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        busy, misalign_err, mem_en, mem_we, ld_valid;
  logic [IDX_W-1:0] mem_idx;
  logic [63:0] mem_wdata, mem_rdata, ld_data;

  logic [63:0] ram [DEPTH];
  logic [63:0] model [DEPTH];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  subword_lane_unit #(.ADDR_W(ADDR_W)) u_subword_lane_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .busy(busy), .misalign_err(misalign_err), .mem_en(mem_en), .mem_we(mem_we),
    .mem_idx(mem_idx), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // synchronous single-port memory, zero-filled
  initial begin
    for (int i = 0; i < DEPTH; i++) begin ram[i] = '0; model[i] = '0; end
    mem_rdata = '0;
  end
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_idx] <= mem_wdata;
      else        mem_rdata    <= ram[mem_idx];
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bench-side view: byte k of a word is the k-th byte from the top
  function automatic logic [7:0] byte_at(input logic [63:0] w, input int k);
    return w[8*(7-k) +: 8];
  endfunction

  function automatic bit ok_align(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    return (a % (1 << sz)) == 0;
  endfunction

  function automatic logic [63:0] model_merge(input logic [63:0] old, input logic [ADDR_W-1:0] a,
                                              input logic [1:0] sz, input logic [63:0] d);
    logic [63:0] w;
    int nb, off;
    w = old; nb = 1 << sz; off = a % 8;
    for (int k = 0; k < nb; k++) w[8*(7-(off+k)) +: 8] = d[8*(nb-1-k) +: 8];
    return w;
  endfunction

  function automatic logic [63:0] model_load(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    logic [63:0] r;
    int nb, off;
    r = '0; nb = 1 << sz; off = a % 8;
    for (int k = 0; k < nb; k++) r = (r << 8) | 64'(byte_at(model[a/8], off + k));
    return r;
  endfunction

  // intrude: hold a full-width store to intr_addr during the busy cycle
  task automatic do_store(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [63:0] d,
                          input bit intrude, input logic [ADDR_W-1:0] intr_addr);
    bit al, full;
    logic [63:0] exp_w;
    al = ok_align(a, sz); full = (sz == 2'd3);
    @(negedge clk);
    req_valid = 1; req_store = 1; req_addr = a; req_size = sz; req_wdata = d;
    #1;
    if (al) begin
      check(mem_en == 1'b1, "R1 store enable", 64'(mem_en), 64'd1);
      check(mem_idx == IDX_W'(a >> 3), "R1 word index", 64'(mem_idx), 64'(a >> 3));
      check(mem_we == full, full ? "R6 direct write" : "R7 read first", 64'(mem_we), 64'(full));
    end else begin
      check(mem_en == 1'b0, "R2 no access when unaligned", 64'(mem_en), 64'd0);
    end
    @(posedge clk); @(negedge clk);
    if (intrude) begin
      req_addr = intr_addr; req_size = 2'd3; req_wdata = 64'hDEAD_DEAD_DEAD_DEAD;
    end else req_valid = 0;
    #1;
    if (!al) begin
      check(misalign_err == 1'b1, "R2 error pulse", 64'(misalign_err), 64'd1);
    end else if (full) begin
      check(busy == 1'b0, "R6 no busy", 64'(busy), 64'd0);
      model[a/8] = d;
    end else begin
      exp_w = model_merge(model[a/8], a, sz, d);
      check(busy == 1'b1, "R7 busy in write", 64'(busy), 64'd1);
      check(mem_en && mem_we, "R7 write cycle", 64'(mem_we), 64'd1);
      check(mem_idx == IDX_W'(a >> 3), "R9 held index", 64'(mem_idx), 64'(a >> 3));
      check(mem_wdata == exp_w, "R7 R8 merged word", mem_wdata, exp_w);
      model[a/8] = exp_w;
    end
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    #1;
    check(busy == 1'b0, "R9 busy released", 64'(busy), 64'd0);
    check(misalign_err == 1'b0, "R2 error one cycle", 64'(misalign_err), 64'd0);
  endtask

  task automatic do_load(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input string req);
    bit al;
    logic [63:0] exp_v;
    al = ok_align(a, sz);
    exp_v = al ? model_load(a, sz) : 64'd0;
    @(negedge clk);
    req_valid = 1; req_store = 0; req_addr = a; req_size = sz; req_wdata = '1;
    #1;
    check(mem_en == al && mem_we == 1'b0, al ? "R1 load read" : "R2 no load access",
          64'(mem_en), 64'(al));
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    #1;
    check(ld_valid == 1'b0, "R11 not early", 64'(ld_valid), 64'd0);
    if (!al) check(misalign_err == 1'b1, "R2 load error", 64'(misalign_err), 64'd1);
    @(posedge clk); @(negedge clk); #1;
    check(ld_valid == al, "R11 valid timing", 64'(ld_valid), 64'(al));
    if (al) check(ld_data == exp_v, req, ld_data, exp_v);
    @(posedge clk); @(negedge clk); #1;
    check(ld_valid == 1'b0, "R11 single pulse", 64'(ld_valid), 64'd0);
  endtask

  task automatic t_reset();
    #1;
    check(!busy && !ld_valid && !misalign_err && !mem_en, "reset outputs idle",
          {60'd0, busy, ld_valid, misalign_err, mem_en}, 64'd0);
  endtask

  task automatic t_unwritten();
    do_load(12'h040, 2'd3, "R10 unwritten word zero");
    do_store(12'h086, 2'd1, 64'h0000_0000_0000_BEEF, 0, '0);  // R10 RMW on unwritten
    do_load(12'h080, 2'd3, "R10 R12 partial store into zero word");
  endtask

  task automatic t_full_and_lanes();
    do_store(12'h010, 2'd3, 64'h0123_4567_89AB_CDEF, 0, '0);
    do_load(12'h010, 2'd3, "R5 full word unchanged");
    do_load(12'h010, 2'd0, "R3 offset 0 is top byte");
    do_load(12'h017, 2'd0, "R3 offset 7 is bottom byte");
    do_load(12'h012, 2'd1, "R4 R12 half zero-extended");
    do_load(12'h014, 2'd2, "R4 R12 quad zero-extended");
  endtask

  task automatic t_partial();
    do_store(12'h013, 2'd0, 64'hFFFF_FFFF_FFFF_FF5A, 0, '0);  // R8 upper ones ignored
    do_load(12'h010, 2'd3, "R7 R8 only lane changed");
    do_store(12'h010, 2'd2, 64'hAAAA_AAAA_1122_3344, 0, '0);
    do_load(12'h010, 2'd3, "R7 quad at offset 0");
  endtask

  task automatic t_misalign();
    do_store(12'h013, 2'd1, 64'h0000_0000_0000_7777, 0, '0);
    do_load(12'h010, 2'd3, "R2 unaligned store no effect");
    do_load(12'h012, 2'd2, "R2 unaligned load");
    do_store(12'h024, 2'd3, 64'h1, 0, '0);
    do_load(12'h020, 2'd3, "R2 unaligned full store no effect");
  endtask

  task automatic t_busy_ignore();
    do_store(12'h031, 2'd0, 64'h0000_0000_0000_00C3, 1, 12'h038);
    do_load(12'h030, 2'd3, "R9 target word correct");
    do_load(12'h038, 2'd3, "R9 intruding store ignored");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_unwritten();
    t_full_and_lanes();
    t_partial();
    t_misalign();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule